// File: doc/BRIEF.md
# DRAM Command Issue Legality Checker

This block answers one question for a memory controller's scheduler: may the candidate command it is looking at go out on the command bus in this cycle? The scheduler presents a command code, a rank, a bank and a row. Alongside these it supplies a free-running cycle count and, for every bank, a timing and state snapshot. Each snapshot holds the bank's state, its open row, and the earliest cycle at which an activate, a read, a write and a precharge each become legal. The snapshots are kept up to date by a separate timing tracker. The answer comes back in the same cycle. The answer depends only on those inputs and on two kinds of state the block keeps for itself.

The first kind is a rolling activate window per rank. Each activate that is actually issued occupies one slot of its rank for a fixed number of cycles. While every slot of a rank is occupied, further activates to that rank are refused. The second kind is a per-bank row-access counter. It counts issued reads and writes to the bank's currently open row, caps how many may be issued, and starts over when the bank is activated again. The scheduler reports with a one-bit strobe that it took the candidate. The block only updates its own state when that strobe coincides with a legal candidate.

Top module: `dram_issue_check`

## Requirements
- R1: Command code 0 (activate) is issuable only when the addressed bank's state is 0 (idle) or 1 (refreshing) and the cycle count is at or past that bank's next-activate cycle; state 2 (row open) or 3 blocks it.
- R2: Command code 0 is refused while the addressed rank already has ACT_LIMIT activates issued within the last T_FAW cycles. An activate issued in cycle t stops counting in cycle t+T_FAW.
- R3: Command codes 1 (read) and 2 (read with auto-precharge) are issuable only when the bank's state is 2, the cycle count is at or past its next-read cycle, the request row equals the bank's open row, and the bank's row-access count is below ACC_MAX.
- R4: Command codes 3 (write) and 4 (write with auto-precharge) obey the same rule as R3, using the bank's next-write cycle instead of its next-read cycle.
- R5: Command code 5 (precharge) is issuable only when the bank's state is 2 and the cycle count is at or past its next-precharge cycle.
- R6: Command code 6 (refresh) is never issuable and does not raise the error output.
- R7: Command code 7 raises bad_cmd_o and is never issuable; codes 0 to 6 keep bad_cmd_o low.
- R8: Each issued read or write (codes 1 to 4) adds one to the addressed bank's row-access count. An issued activate to that bank clears the count. Other banks' counts are unaffected.
- R9: The activate windows and row-access counts change only in a cycle where cmd_issue_i is high and issuable_o is high. A candidate that is not taken, or that is refused, leaves them as they were.
- R10: Synchronous reset empties every activate window and clears every row-access count.
- R11: Activate windows are kept separately per rank; a full window in one rank does not block activates in another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Candidate command code |
| rank_i | input | RK_W | Candidate rank |
| bank_i | input | BK_W | Candidate bank within the rank |
| row_i | input | ROW_W | Candidate row |
| cycle_i | input | CYC_W | Free-running cycle count |
| cmd_issue_i | input | 1 | Scheduler takes the candidate this cycle |
| bank_state_i | input | NB*2 | Per-bank state code, bank r*BANKS+b at bits [2*i +: 2] |
| open_row_i | input | NB*ROW_W | Per-bank open row |
| next_act_i | input | NB*CYC_W | Per-bank earliest activate cycle |
| next_rd_i | input | NB*CYC_W | Per-bank earliest read cycle |
| next_wr_i | input | NB*CYC_W | Per-bank earliest write cycle |
| next_pre_i | input | NB*CYC_W | Per-bank earliest precharge cycle |
| issuable_o | output | 1 | Candidate is legal this cycle |
| bad_cmd_o | output | 1 | Candidate command code is not recognised |

## Verification
The assertions assume that rank_i and bank_i address a bank that exists. They also assume the cycle count does not wrap within a run, since the earliest-cycle comparisons are plain unsigned magnitude tests. The stimulus keeps every address in range. It starts the cycle count at zero, sets the next-command cycles a few cycles either side of the current count, and stays far below the counter's width. Bank state snapshots are chosen by the bench freely, without any claim to mirror the real bank. The checks on the activate window and the row-access counter therefore depend only on which candidates the bench marks as taken.

// File: rtl/dram_chk_pkg.sv
package dram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_RDA = 3'd2,
    CMD_WR  = 3'd3,
    CMD_WRA = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_REFR = 2'd1,
    BK_OPEN = 2'd2
  } bank_st_e;

endpackage

// File: rtl/faw_window.sv
module faw_window #(
  parameter int SLOTS = 4,
  parameter int T_FAW = 20,
  localparam int TW = (T_FAW > 1) ? $clog2(T_FAW + 1) : 1,
  localparam int OW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic [OW-1:0] occ,
  output logic          full
);

  logic [TW-1:0] left [SLOTS];
  logic [$clog2(SLOTS+1)-1:0] pick;
  logic found;

  // lowest free slot takes the next activate
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!found && left[i] == '0) begin
        pick  = ($clog2(SLOTS+1))'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) left[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (load && found && pick == ($clog2(SLOTS+1))'(i))
          left[i] <= TW'(T_FAW - 1);
        else if (left[i] != '0)
          left[i] <= left[i] - 1'b1;
      end
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < SLOTS; i++)
      if (left[i] != '0) occ = occ + 1'b1;
  end

  assign full = (occ >= OW'(SLOTS));

endmodule

// File: rtl/row_access_ctr.sv
module row_access_ctr #(
  parameter int ACC_MAX = 16,
  localparam int AW = $clog2(ACC_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] cnt,
  output logic          at_cap
);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt < AW'(ACC_MAX))
      cnt <= cnt + 1'b1;
  end

  assign at_cap = (cnt >= AW'(ACC_MAX));

endmodule

// File: rtl/cmd_rules.sv
module cmd_rules
  import dram_chk_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int CYC_W = 32
) (
  input  logic [2:0]       cmd,
  input  logic [1:0]       st,
  input  logic [ROW_W-1:0] open_row,
  input  logic [ROW_W-1:0] req_row,
  input  logic [CYC_W-1:0] cyc,
  input  logic [CYC_W-1:0] n_act,
  input  logic [CYC_W-1:0] n_rd,
  input  logic [CYC_W-1:0] n_wr,
  input  logic [CYC_W-1:0] n_pre,
  input  logic             win_full,
  input  logic             acc_cap,
  output logic             ok,
  output logic             bad
);

  logic is_open, row_hit;
  assign is_open = (st == BK_OPEN);
  assign row_hit = (req_row == open_row);

  always_comb begin
    ok  = 1'b0;
    bad = 1'b0;
    case (cmd)
      CMD_ACT:          ok = (st == BK_IDLE || st == BK_REFR) && (cyc >= n_act) && !win_full;
      CMD_RD, CMD_RDA:  ok = is_open && (cyc >= n_rd) && row_hit && !acc_cap;
      CMD_WR, CMD_WRA:  ok = is_open && (cyc >= n_wr) && row_hit && !acc_cap;
      CMD_PRE:          ok = is_open && (cyc >= n_pre);
      CMD_REF:          ok = 1'b0;
      default:          bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/dram_issue_check.sv
module dram_issue_check
  import dram_chk_pkg::*;
#(
  parameter int RANKS     = 2,
  parameter int BANKS     = 4,
  parameter int ROW_W     = 14,
  parameter int CYC_W     = 32,
  parameter int ACC_MAX   = 16,
  parameter int T_FAW     = 20,
  parameter int ACT_LIMIT = 4,
  localparam int NB   = RANKS * BANKS,
  localparam int RK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int GI_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            cmd_i,
  input  logic [RK_W-1:0]       rank_i,
  input  logic [BK_W-1:0]       bank_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [CYC_W-1:0]      cycle_i,
  input  logic                  cmd_issue_i,
  input  logic [NB*2-1:0]       bank_state_i,
  input  logic [NB*ROW_W-1:0]   open_row_i,
  input  logic [NB*CYC_W-1:0]   next_act_i,
  input  logic [NB*CYC_W-1:0]   next_rd_i,
  input  logic [NB*CYC_W-1:0]   next_wr_i,
  input  logic [NB*CYC_W-1:0]   next_pre_i,
  output logic                  issuable_o,
  output logic                  bad_cmd_o
);

  localparam int OW = $clog2(ACT_LIMIT + 1);
  localparam int AW = $clog2(ACC_MAX + 1);

  logic [GI_W-1:0]  gidx;
  logic [1:0]       sel_state;
  logic [ROW_W-1:0] sel_row;
  logic [CYC_W-1:0] sel_act, sel_rd, sel_wr, sel_pre;
  logic             fire, fire_act, fire_rw, is_rw;

  logic [RANKS-1:0]      rk_full, rk_load;
  logic [RANKS*OW-1:0]   faw_occ;
  logic [NB-1:0]         bk_cap, bk_inc, bk_clr;
  logic [NB*AW-1:0]      acc_cnt;

  assign gidx = GI_W'(int'(rank_i) * BANKS + int'(bank_i));

  // per-bank snapshot selection
  always_comb begin
    sel_state = '0;
    sel_row   = '0;
    sel_act   = '0;
    sel_rd    = '0;
    sel_wr    = '0;
    sel_pre   = '0;
    for (int b = 0; b < NB; b++) begin
      if (gidx == GI_W'(b)) begin
        sel_state = bank_state_i[b*2 +: 2];
        sel_row   = open_row_i[b*ROW_W +: ROW_W];
        sel_act   = next_act_i[b*CYC_W +: CYC_W];
        sel_rd    = next_rd_i[b*CYC_W +: CYC_W];
        sel_wr    = next_wr_i[b*CYC_W +: CYC_W];
        sel_pre   = next_pre_i[b*CYC_W +: CYC_W];
      end
    end
  end

  cmd_rules #(.ROW_W(ROW_W), .CYC_W(CYC_W)) u_rules (
    .cmd      (cmd_i),
    .st       (sel_state),
    .open_row (sel_row),
    .req_row  (row_i),
    .cyc      (cycle_i),
    .n_act    (sel_act),
    .n_rd     (sel_rd),
    .n_wr     (sel_wr),
    .n_pre    (sel_pre),
    .win_full (rk_full[rank_i]),
    .acc_cap  (bk_cap[gidx]),
    .ok       (issuable_o),
    .bad      (bad_cmd_o)
  );

  assign is_rw    = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA) ||
                    (cmd_i == CMD_WR) || (cmd_i == CMD_WRA);
  assign fire     = cmd_issue_i && issuable_o;
  assign fire_act = fire && (cmd_i == CMD_ACT);
  assign fire_rw  = fire && is_rw;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    assign rk_load[r] = fire_act && (rank_i == RK_W'(r));
    faw_window #(.SLOTS(ACT_LIMIT), .T_FAW(T_FAW)) u_win (
      .clk  (clk),
      .rst  (rst),
      .load (rk_load[r]),
      .occ  (faw_occ[r*OW +: OW]),
      .full (rk_full[r])
    );
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bk_inc[b] = fire_rw  && (gidx == GI_W'(b));
    assign bk_clr[b] = fire_act && (gidx == GI_W'(b));
    row_access_ctr #(.ACC_MAX(ACC_MAX)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clr    (bk_clr[b]),
      .inc    (bk_inc[b]),
      .cnt    (acc_cnt[b*AW +: AW]),
      .at_cap (bk_cap[b])
    );
  end

endmodule

// File: rtl/dram_issue_check_sva.sv
module dram_issue_check_sva #(
  parameter int NB        = 8,
  parameter int RANKS     = 2,
  parameter int ROW_W     = 14,
  parameter int ACC_MAX   = 16,
  parameter int ACT_LIMIT = 4,
  parameter int GI_W      = 3,
  localparam int OW = $clog2(ACT_LIMIT + 1),
  localparam int AW = $clog2(ACC_MAX + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          cmd_i,
  input logic [GI_W-1:0]     gidx,
  input logic [1:0]          sel_state,
  input logic [ROW_W-1:0]    sel_row,
  input logic [ROW_W-1:0]    row_i,
  input logic                fire,
  input logic                issuable_o,
  input logic                bad_cmd_o,
  input logic [RANKS*OW-1:0] faw_occ,
  input logic [NB*AW-1:0]    acc_cnt
);

  a_r7_bad_blocks: assert property (@(posedge clk) disable iff (rst)
    bad_cmd_o |-> !issuable_o);

  a_r6_refresh_refused: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd6) |-> (!issuable_o && !bad_cmd_o));

  a_r1_act_needs_closed: assert property (@(posedge clk) disable iff (rst)
    (issuable_o && cmd_i == 3'd0) |-> (sel_state == 2'd0 || sel_state == 2'd1));

  a_r3_rw_open_row: assert property (@(posedge clk) disable iff (rst)
    (issuable_o && cmd_i >= 3'd1 && cmd_i <= 3'd4) |-> (sel_state == 2'd2 && row_i == sel_row));

  a_r5_pre_needs_open: assert property (@(posedge clk) disable iff (rst)
    (issuable_o && cmd_i == 3'd5) |-> (sel_state == 2'd2));

  for (genvar r = 0; r < RANKS; r++) begin : g_rk
    a_r2_window_bounded: assert property (@(posedge clk) disable iff (rst)
      faw_occ[r*OW +: OW] <= OW'(ACT_LIMIT));
  end

  for (genvar b = 0; b < NB; b++) begin : g_bk
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
      acc_cnt[b*AW +: AW] <= AW'(ACC_MAX));
    a_r8_act_clears: assert property (@(posedge clk) disable iff (rst)
      (fire && cmd_i == 3'd0 && gidx == GI_W'(b)) |=> (acc_cnt[b*AW +: AW] == '0));
  end

endmodule

bind dram_issue_check dram_issue_check_sva #(
  .NB(NB), .RANKS(RANKS), .ROW_W(ROW_W), .ACC_MAX(ACC_MAX),
  .ACT_LIMIT(ACT_LIMIT), .GI_W(GI_W)
) u_sva (
  .clk        (clk),
  .rst        (rst),
  .cmd_i      (cmd_i),
  .gidx       (gidx),
  .sel_state  (sel_state),
  .sel_row    (sel_row),
  .row_i      (row_i),
  .fire       (fire),
  .issuable_o (issuable_o),
  .bad_cmd_o  (bad_cmd_o),
  .faw_occ    (faw_occ),
  .acc_cnt    (acc_cnt)
);

// File: tb/dram_issue_check_bench.sv
`timescale 1ns/1ps
module dram_issue_check_bench;

  localparam int RANKS = 2, BANKS = 4, ROW_W = 8, CYC_W = 32;
  localparam int ACC_MAX = 3, T_FAW = 12, ACT_LIMIT = 4;
  localparam int NB = RANKS * BANKS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [0:0] rank = '0;
  logic [1:0] bank = '0;
  logic [ROW_W-1:0] row = '0;
  logic [CYC_W-1:0] cyc = '0;
  logic issue = 1'b0;
  logic issuable, bad;

  logic [1:0]       st   [NB];
  logic [ROW_W-1:0] orow [NB];
  logic [CYC_W-1:0] nact [NB], nrd [NB], nwr [NB], npre [NB];

  logic [NB*2-1:0]     st_f;
  logic [NB*ROW_W-1:0] row_f;
  logic [NB*CYC_W-1:0] act_f, rd_f, wr_f, pre_f;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      st_f[b*2 +: 2]          = st[b];
      row_f[b*ROW_W +: ROW_W] = orow[b];
      act_f[b*CYC_W +: CYC_W] = nact[b];
      rd_f[b*CYC_W +: CYC_W]  = nrd[b];
      wr_f[b*CYC_W +: CYC_W]  = nwr[b];
      pre_f[b*CYC_W +: CYC_W] = npre[b];
    end
  end

  dram_issue_check #(
    .RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .CYC_W(CYC_W),
    .ACC_MAX(ACC_MAX), .T_FAW(T_FAW), .ACT_LIMIT(ACT_LIMIT)
  ) u_dram_issue_check (
    .clk(clk), .rst(rst), .cmd_i(cmd), .rank_i(rank), .bank_i(bank),
    .row_i(row), .cycle_i(cyc), .cmd_issue_i(issue),
    .bank_state_i(st_f), .open_row_i(row_f), .next_act_i(act_f),
    .next_rd_i(rd_f), .next_wr_i(wr_f), .next_pre_i(pre_f),
    .issuable_o(issuable), .bad_cmd_o(bad)
  );

  task automatic chk(input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_bank(input int gi, input logic [1:0] s, input logic [ROW_W-1:0] r,
                          input int da, input int dr, input int dw, input int dp);
    st[gi]   = s;
    orow[gi] = r;
    nact[gi] = CYC_W'(int'(cyc) + da);
    nrd[gi]  = CYC_W'(int'(cyc) + dr);
    nwr[gi]  = CYC_W'(int'(cyc) + dw);
    npre[gi] = CYC_W'(int'(cyc) + dp);
  endtask

  task automatic set_req(input logic [2:0] c, input int rk, input int bk, input logic [ROW_W-1:0] r);
    cmd = c; rank = 1'(rk); bank = 2'(bk); row = r;
  endtask

  // present at a falling edge, not taken
  task automatic present(input logic [2:0] c, input int rk, input int bk, input logic [ROW_W-1:0] r);
    @(negedge clk);
    set_req(c, rk, bk, r);
    issue = 1'b0;
    #1;
  endtask

  // present and mark as taken across one rising edge
  task automatic take(input logic [2:0] c, input int rk, input int bk, input logic [ROW_W-1:0] r);
    @(negedge clk);
    set_req(c, rk, bk, r);
    issue = 1'b1;
    @(posedge clk);
    #1 issue = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; issue = 1'b0;
    for (int b = 0; b < NB; b++) begin
      st[b] = 2'd0; orow[b] = '0;
      nact[b] = '0; nrd[b] = '0; nwr[b] = '0; npre[b] = '0;
    end
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    present(3'd0, 0, 0, 8'h00);
    chk("R10 activate legal after reset", issuable, 1'b1);
    chk("R7 no error after reset", bad, 1'b0);
  endtask

  task automatic t_act_rules();
    do_reset();
    set_bank(1, 2'd2, 8'h10, 0, 0, 0, 0);
    present(3'd0, 0, 1, 8'h10);
    chk("R1 activate on open bank", issuable, 1'b0);
    set_bank(1, 2'd1, 8'h10, 0, 0, 0, 0);
    present(3'd0, 0, 1, 8'h10);
    chk("R1 activate on refreshing bank", issuable, 1'b1);
    set_bank(1, 2'd0, 8'h10, 6, 0, 0, 0);
    present(3'd0, 0, 1, 8'h10);
    chk("R1 activate before next-activate", issuable, 1'b0);
    @(negedge clk);
    set_bank(1, 2'd0, 8'h10, 0, 0, 0, 0);
    #1 chk("R1 activate at next-activate cycle", issuable, 1'b1);
    set_bank(1, 2'd3, 8'h10, 0, 0, 0, 0);
    #1 chk("R1 activate with state 3", issuable, 1'b0);
  endtask

  task automatic t_rw_rules();
    do_reset();
    set_bank(5, 2'd2, 8'h33, 0, 0, 0, 0);
    present(3'd1, 1, 1, 8'h33);
    chk("R3 read to open row", issuable, 1'b1);
    present(3'd2, 1, 1, 8'h34);
    chk("R3 read-ap to other row", issuable, 1'b0);
    set_bank(5, 2'd2, 8'h33, 0, 3, 0, 0);
    present(3'd2, 1, 1, 8'h33);
    chk("R3 read-ap before next-read", issuable, 1'b0);
    present(3'd3, 1, 1, 8'h33);
    chk("R4 write ignores next-read", issuable, 1'b1);
    set_bank(5, 2'd2, 8'h33, 0, 0, 4, 0);
    present(3'd4, 1, 1, 8'h33);
    chk("R4 write-ap before next-write", issuable, 1'b0);
    @(negedge clk);
    set_bank(5, 2'd2, 8'h33, 0, 0, 0, 0);
    #1 chk("R4 write-ap at next-write cycle", issuable, 1'b1);
    set_bank(5, 2'd0, 8'h33, 0, 0, 0, 0);
    present(3'd1, 1, 1, 8'h33);
    chk("R3 read on idle bank", issuable, 1'b0);
    present(3'd3, 1, 1, 8'h33);
    chk("R4 write on idle bank", issuable, 1'b0);
  endtask

  task automatic t_pre_rules();
    do_reset();
    set_bank(2, 2'd2, 8'h01, 0, 0, 0, 5);
    present(3'd5, 0, 2, 8'h77);
    chk("R5 precharge before next-precharge", issuable, 1'b0);
    @(negedge clk);
    set_bank(2, 2'd2, 8'h01, 0, 0, 0, 0);
    #1 chk("R5 precharge at next-precharge cycle", issuable, 1'b1);
    set_bank(2, 2'd0, 8'h01, 0, 0, 0, 0);
    present(3'd5, 0, 2, 8'h01);
    chk("R5 precharge on idle bank", issuable, 1'b0);
  endtask

  task automatic t_ref_bad();
    do_reset();
    set_bank(0, 2'd2, 8'h05, 0, 0, 0, 0);
    present(3'd6, 0, 0, 8'h05);
    chk("R6 refresh never issuable", issuable, 1'b0);
    chk("R6 refresh raises no error", bad, 1'b0);
    present(3'd7, 0, 0, 8'h05);
    chk("R7 code 7 raises error", bad, 1'b1);
    chk("R7 code 7 not issuable", issuable, 1'b0);
    present(3'd1, 0, 0, 8'h05);
    chk("R7 read code raises no error", bad, 1'b0);
  endtask

  task automatic t_row_access();
    do_reset();
    set_bank(2, 2'd2, 8'h40, 0, 0, 0, 0);
    set_bank(3, 2'd2, 8'h41, 0, 0, 0, 0);
    // R9: held untaken, and taken while refused
    present(3'd1, 0, 2, 8'h40);
    repeat (6) @(negedge clk);
    repeat (4) take(3'd1, 0, 2, 8'h41);
    take(3'd1, 0, 2, 8'h40);
    take(3'd3, 0, 2, 8'h40);
    present(3'd1, 0, 2, 8'h40);
    chk("R9 untaken/refused requests not counted", issuable, 1'b1);
    take(3'd4, 0, 2, 8'h40);
    present(3'd2, 0, 2, 8'h40);
    chk("R8 read capped at ACC_MAX", issuable, 1'b0);
    present(3'd3, 0, 2, 8'h40);
    chk("R8 write capped at ACC_MAX", issuable, 1'b0);
    present(3'd1, 0, 3, 8'h41);
    chk("R8 other bank uncounted", issuable, 1'b1);
    set_bank(2, 2'd0, 8'h40, 0, 0, 0, 0);
    take(3'd0, 0, 2, 8'h40);
    set_bank(2, 2'd2, 8'h40, 0, 0, 0, 0);
    present(3'd1, 0, 2, 8'h40);
    chk("R8 activate clears count", issuable, 1'b1);
    repeat (ACC_MAX) take(3'd1, 0, 3, 8'h41);
    present(3'd1, 0, 3, 8'h41);
    chk("R8 bank 3 capped", issuable, 1'b0);
    do_reset();
    set_bank(3, 2'd2, 8'h41, 0, 0, 0, 0);
    present(3'd1, 0, 3, 8'h41);
    chk("R10 reset clears row count", issuable, 1'b1);
  endtask

  task automatic t_window();
    int t0;
    do_reset();
    @(negedge clk);
    t0 = int'(cyc) + 1;
    for (int b = 0; b < ACT_LIMIT; b++) take(3'd0, 0, b, 8'h00);
    present(3'd0, 0, 0, 8'h00);
    chk("R2 fifth activate refused", issuable, 1'b0);
    present(3'd0, 1, 0, 8'h00);
    chk("R11 other rank unaffected", issuable, 1'b1);
    while (int'(cyc) != t0 + T_FAW - 1) @(negedge clk);
    set_req(3'd0, 0, 0, 8'h00);
    #1 chk("R2 refused one cycle before window ends", issuable, 1'b0);
    @(negedge clk);
    #1 chk("R2 allowed when first activate expires", issuable, 1'b1);
    for (int b = 0; b < ACT_LIMIT; b++) take(3'd0, 0, b, 8'h00);
    do_reset();
    present(3'd0, 0, 1, 8'h00);
    chk("R10 reset empties window", issuable, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      st[b] = 2'd0; orow[b] = '0;
      nact[b] = '0; nrd[b] = '0; nwr[b] = '0; npre[b] = '0;
    end
    t_reset_state();
    t_act_rules();
    t_rw_rules();
    t_pre_rules();
    t_ref_bad();
    t_row_access();
    t_window();
    report();
  end

endmodule